// File: doc/BRIEF.md
# Tester Pin Channel Pattern Formatter

This block is one pin channel of a digital test system. It keeps a pattern store with one entry per test cycle. Each entry holds a 3-bit action code for each phase of the cycle. While the channel runs, the code of the current phase either drives the device pin or turns the driver off and compares the sensed pin state against an expectation. Drive actions are a static level or a pulse. Compare actions are expect low, expect high, expect high-impedance, or ignore.

Two externally generated strobes pace the channel. The mux strobe moves the channel to the next phase, and to the next cycle after the last phase. The shift strobe marks the point inside a phase where pulse codes reach their active level and where compare codes sample the pin. A one-bit serial line beside the pin loads the pattern store one frame at a time, and the same transfer returns the recorded response bits. A small control register holds an enable bit and a local hold bit. A global force-static input freezes the channel whatever the local hold bit says.

Top module: `pin_channel_fmt`

## Requirements
- R1: A synchronous reset clears the cycle address, the phase select, the fail flag, both control bits and the serial bit count, and turns the driver off with a low drive value.
- R2: Codes with bit 2 = 0 drive the pin. Code 000 drives low and code 001 drives high, with the driver enabled. The registered pin outputs follow the current code one clock later.
- R3: Code 010 (pulse high) drives high in the clock after a shift strobe and low otherwise. Code 011 (pulse low) is the inverse. The driver stays enabled in both cases.
- R4: Every code with bit 2 = 1 (100 expect low, 101 expect high, 110 expect high-impedance, 111 ignore) turns the driver off for that phase.
- R5: On a shift strobe during a compare phase, the sticky fail flag sets if expect low sees anything but low, if expect high sees anything but high, or if expect high-impedance sees a driven level. The ignore code never sets it. Only reset clears the flag. The pin_sense encoding is 00 low, 01 high, 1x high-impedance.
- R6: Each compare phase records one response bit at its shift strobe, equal to 1 exactly when the pin was sensed high. While disabled, ser_out gives the response bit of phase 0 during frame bit 0 and of phase 1 during frame bit 1, for the current address, and 0 during frame bits 2 to 5.
- R7: While disabled, each ser_en clock shifts ser_in in, least significant bit first. After 6 bits the frame is written to the current address, with bits [2:0] as the phase 0 code and bits [5:3] as the phase 1 code, and the address advances, wrapping after the last entry.
- R8: While running, a mux strobe in phase 0 selects phase 1. In phase 1 it returns to phase 0 and advances the address, which wraps from DEPTH-1 to 0.
- R9: A control write loads ctl_wdata[1] as enable and ctl_wdata[0] as local hold, and clears the address, the phase and the serial bit count.
- R10: While local hold or force_static is set, strobes have no effect, and the address, phase, pin outputs and fail flag keep their values.
- R11: While disabled, mux and shift strobes are ignored. While enabled, ser_en is ignored and the pattern store is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control data: bit 1 enable, bit 0 local hold |
| force_static | input | 1 | Global freeze, overrides local hold |
| mux_pulse | input | 1 | Phase advance strobe |
| shift_pulse | input | 1 | In-phase pulse and sample strobe |
| pin_sense | input | 2 | Sensed pin: 00 low, 01 high, 1x high-impedance |
| ser_en | input | 1 | Serial transfer clock enable |
| ser_in | input | 1 | Serial pattern data in |
| ser_out | output | 1 | Serial response data out |
| drv_en | output | 1 | Pin driver enable |
| drv_val | output | 1 | Pin drive level |
| fail | output | 1 | Sticky compare failure |

## Verification
The bench builds the channel with DEPTH = 8 and two phases. With that depth, a full walk of every cycle and phase takes only a few dozen strobes, so the address wrap from the last entry back to entry 0 is checked for both pattern execution and serial loading. The small depth also means every stored code is read back through the pin within the run, and every response bit is unloaded over the serial line. Pattern contents and sensed values come from a seeded random source. Fixed entries are placed in the first slots so that both pulse codes, the expect high-impedance match and mismatch, and a repeated failure that shows the flag is sticky all occur on every run.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

   localparam int CODE_BITS    = 3;
   localparam int CMP_BIT      = 2;
   localparam int CTL_HOLD_BIT = 0;
   localparam int CTL_EN_BIT   = 1;

   localparam logic [1:0] SENSE_LOW  = 2'b00;
   localparam logic [1:0] SENSE_HIGH = 2'b01;

   typedef enum logic [CODE_BITS-1:0] {
      ACT_DRIVE_LO  = 3'b000,
      ACT_DRIVE_HI  = 3'b001,
      ACT_PULSE_HI  = 3'b010,
      ACT_PULSE_LO  = 3'b011,
      ACT_WANT_LO   = 3'b100,
      ACT_WANT_HI   = 3'b101,
      ACT_WANT_Z    = 3'b110,
      ACT_IGNORE    = 3'b111
   } act_e;

   // Returns 1 when a compare code disagrees with the sensed pin state.
   function automatic logic sense_mismatch(input logic [CODE_BITS-1:0] code,
                                           input logic [1:0]           sense);
      logic miss;
      miss = 1'b0;
      case (code[1:0])
         2'b00:   miss = (sense != SENSE_LOW);
         2'b01:   miss = (sense != SENSE_HIGH);
         2'b10:   miss = !sense[1];
         default: miss = 1'b0;
      endcase
      return miss;
   endfunction

endpackage

// File: rtl/pcf_seq.sv
module pcf_seq #(
   parameter int DEPTH  = 128,
   parameter int PHASES = 2,
   parameter int ADDR_W = 7,
   parameter int PH_W   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_wr,
   input  logic [1:0]        ctl_wdata,
   input  logic              force_static,
   input  logic              mux_pulse,
   input  logic              frame_done,
   output logic              enable,
   output logic              run,
   output logic [ADDR_W-1:0] addr,
   output logic [PH_W-1:0]   phase
);
   import pcf_pkg::*;

   logic              en_q, hold_q;
   logic [ADDR_W-1:0] addr_q, addr_step;
   logic [PH_W-1:0]   phase_q;
   logic              last_addr, last_phase;

   assign last_addr  = (addr_q == ADDR_W'(DEPTH - 1));
   assign last_phase = (phase_q == PH_W'(PHASES - 1));
   assign addr_step  = last_addr ? '0 : addr_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= 1'b0;
         hold_q <= 1'b0;
      end else if (ctl_wr) begin
         en_q   <= ctl_wdata[CTL_EN_BIT];
         hold_q <= ctl_wdata[CTL_HOLD_BIT];
      end
   end

   assign enable = en_q;
   assign run    = en_q & ~hold_q & ~force_static;

   always_ff @(posedge clk) begin
      if (rst || ctl_wr) begin
         addr_q  <= '0;
         phase_q <= '0;
      end else if (run && mux_pulse) begin
         if (last_phase) begin
            phase_q <= '0;
            addr_q  <= addr_step;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end else if (frame_done) begin
         addr_q <= addr_step;
      end
   end

   assign addr  = addr_q;
   assign phase = phase_q;

endmodule

// File: rtl/pcf_serial.sv
module pcf_serial #(
   parameter int PHASES  = 2,
   parameter int FRAME_W = 6,
   parameter int CNT_W   = 3,
   parameter int PH_W    = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clear,
   input  logic               active,
   input  logic               enable,
   input  logic               ser_in,
   input  logic [PHASES-1:0]  resp_word,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_word,
   output logic               ser_out
);
   logic [CNT_W-1:0]   bit_q;
   logic [FRAME_W-2:0] asm_q;
   logic               last_bit, in_resp;

   assign last_bit = (bit_q == CNT_W'(FRAME_W - 1));

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         bit_q <= '0;
      end else if (active) begin
         bit_q <= last_bit ? '0 : bit_q + 1'b1;
      end
   end

   // First bit of a frame ends up in the lowest position.
   always_ff @(posedge clk) begin
      if (active) begin
         asm_q <= {ser_in, asm_q[FRAME_W-2:1]};
      end
   end

   assign frame_done = active & last_bit;
   assign frame_word = {ser_in, asm_q};

   assign in_resp = (bit_q < CNT_W'(PHASES));
   assign ser_out = ~enable & in_resp & resp_word[bit_q[PH_W-1:0]];

endmodule

// File: rtl/pcf_store.sv
module pcf_store #(
   parameter int DEPTH   = 128,
   parameter int PHASES  = 2,
   parameter int CODE_W  = 3,
   parameter int FRAME_W = 6,
   parameter int ADDR_W  = 7,
   parameter int PH_W    = 1
) (
   input  logic               clk,
   input  logic               frame_we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [FRAME_W-1:0] frame_word,
   input  logic [PH_W-1:0]    phase,
   input  logic               resp_we,
   input  logic               resp_bit,
   output logic [CODE_W-1:0]  code,
   output logic [PHASES-1:0]  resp_word
);
   logic [CODE_W-1:0] code_by_ph [PHASES];

   for (genvar g = 0; g < PHASES; g++) begin : g_phase
      logic [CODE_W-1:0] pat_q  [DEPTH];
      logic              resp_q [DEPTH];

      always_ff @(posedge clk) begin
         if (frame_we) begin
            pat_q[addr] <= frame_word[g*CODE_W +: CODE_W];
         end
         if (resp_we && (phase == PH_W'(g))) begin
            resp_q[addr] <= resp_bit;
         end
      end

      assign code_by_ph[g] = pat_q[addr];
      assign resp_word[g]  = resp_q[addr];
   end

   assign code = code_by_ph[phase];

endmodule

// File: rtl/pcf_fmt.sv
module pcf_fmt (
   input  logic       clk,
   input  logic       rst,
   input  logic       run,
   input  logic       shift_pulse,
   input  logic [2:0] code,
   input  logic [1:0] sense,
   output logic       drv_en,
   output logic       drv_val,
   output logic       fail,
   output logic       resp_we,
   output logic       resp_bit
);
   import pcf_pkg::*;

   logic en_d, val_d, is_cmp;

   assign is_cmp = code[CMP_BIT];

   always_comb begin
      en_d  = 1'b1;
      val_d = 1'b0;
      case (act_e'(code))
         ACT_DRIVE_LO: val_d = 1'b0;
         ACT_DRIVE_HI: val_d = 1'b1;
         ACT_PULSE_HI: val_d = shift_pulse;
         ACT_PULSE_LO: val_d = ~shift_pulse;
         default:      en_d  = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         drv_en  <= 1'b0;
         drv_val <= 1'b0;
         fail    <= 1'b0;
      end else if (run) begin
         drv_en  <= en_d;
         drv_val <= val_d;
         if (shift_pulse && is_cmp && sense_mismatch(code, sense)) begin
            fail <= 1'b1;
         end
      end
   end

   assign resp_we  = run & shift_pulse & is_cmp;
   assign resp_bit = (sense == SENSE_HIGH);

endmodule

// File: rtl/pin_channel_fmt.sv
module pin_channel_fmt #(
   parameter int DEPTH  = 128,
   parameter int PHASES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ctl_wr,
   input  logic [1:0] ctl_wdata,
   input  logic       force_static,
   input  logic       mux_pulse,
   input  logic       shift_pulse,
   input  logic [1:0] pin_sense,
   input  logic       ser_en,
   input  logic       ser_in,
   output logic       ser_out,
   output logic       drv_en,
   output logic       drv_val,
   output logic       fail
);
   import pcf_pkg::*;

   localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PH_W    = (PHASES > 1) ? $clog2(PHASES) : 1;
   localparam int FRAME_W = PHASES * CODE_BITS;
   localparam int CNT_W   = $clog2(FRAME_W);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pin_channel_fmt: DEPTH must be at least 2");
   end
   if (PHASES < 2) begin : g_bad_phases
      $error("pin_channel_fmt: PHASES must be at least 2");
   end

   logic                 enable, run;
   logic [ADDR_W-1:0]    cur_addr;
   logic [PH_W-1:0]      cur_phase;
   logic [CODE_BITS-1:0] cur_code;
   logic [PHASES-1:0]    resp_word;
   logic [FRAME_W-1:0]   frame_word;
   logic                 frame_done, ser_active;
   logic                 resp_we, resp_bit;

   assign ser_active = ser_en & ~enable & ~ctl_wr;

   pcf_seq #(
      .DEPTH(DEPTH), .PHASES(PHASES), .ADDR_W(ADDR_W), .PH_W(PH_W)
   ) u_seq (
      .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .force_static(force_static), .mux_pulse(mux_pulse),
      .frame_done(frame_done), .enable(enable), .run(run),
      .addr(cur_addr), .phase(cur_phase)
   );

   pcf_serial #(
      .PHASES(PHASES), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .PH_W(PH_W)
   ) u_serial (
      .clk(clk), .rst(rst), .clear(ctl_wr), .active(ser_active),
      .enable(enable), .ser_in(ser_in), .resp_word(resp_word),
      .frame_done(frame_done), .frame_word(frame_word), .ser_out(ser_out)
   );

   pcf_store #(
      .DEPTH(DEPTH), .PHASES(PHASES), .CODE_W(CODE_BITS),
      .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .PH_W(PH_W)
   ) u_store (
      .clk(clk), .frame_we(frame_done), .addr(cur_addr),
      .frame_word(frame_word), .phase(cur_phase), .resp_we(resp_we),
      .resp_bit(resp_bit), .code(cur_code), .resp_word(resp_word)
   );

   pcf_fmt u_fmt (
      .clk(clk), .rst(rst), .run(run), .shift_pulse(shift_pulse),
      .code(cur_code), .sense(pin_sense), .drv_en(drv_en),
      .drv_val(drv_val), .fail(fail), .resp_we(resp_we),
      .resp_bit(resp_bit)
   );

endmodule

// File: rtl/pin_channel_fmt_chk.sv
module pin_channel_fmt_chk #(
   parameter int DEPTH  = 128,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst,
   input logic              force_static,
   input logic              ctl_wr,
   input logic              run,
   input logic [2:0]        code,
   input logic              frame_done,
   input logic [ADDR_W-1:0] addr,
   input logic              drv_en,
   input logic              drv_val,
   input logic              fail
);

   p_drive_enables_r2: assert property (@(posedge clk) disable iff (rst)
      (run && !code[2]) |=> drv_en);

   p_compare_offs_r4: assert property (@(posedge clk) disable iff (rst)
      (run && code[2]) |=> !drv_en);

   p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      fail |=> fail);

   p_frame_step_r7: assert property (@(posedge clk) disable iff (rst)
      (frame_done && !ctl_wr) |=>
         (addr == (($past(addr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(addr) + 1'b1)));

   p_static_freeze_r10: assert property (@(posedge clk) disable iff (rst)
      (force_static && !ctl_wr && !frame_done) |=>
         ($stable(drv_en) && $stable(drv_val) && $stable(addr) && $stable(fail)));

endmodule

bind pin_channel_fmt pin_channel_fmt_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .force_static(force_static), .ctl_wr(ctl_wr),
   .run(run), .code(cur_code), .frame_done(frame_done), .addr(cur_addr),
   .drv_en(drv_en), .drv_val(drv_val), .fail(fail)
);

// File: tb/pin_channel_fmt_bench.sv
module pin_channel_fmt_bench;
   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst, ctl_wr, force_static, mux_pulse, shift_pulse;
   logic [1:0] ctl_wdata, pin_sense;
   logic       ser_en, ser_in;
   logic       ser_out, drv_en, drv_val, fail;

   int   errs = 0;
   int   checks = 0;
   bit   done = 1'b0;

   logic [2:0] pat_a  [DEPTH][2];
   logic [2:0] pat_b  [DEPTH][2];
   logic [1:0] sense_b[DEPTH][2];
   logic       resp_b [DEPTH][2];
   logic       exp_fail;
   logic [1:0] held;

   always #10 clk = ~clk;

   pin_channel_fmt #(.DEPTH(DEPTH), .PHASES(2)) u_pin_channel_fmt (
      .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .force_static(force_static), .mux_pulse(mux_pulse),
      .shift_pulse(shift_pulse), .pin_sense(pin_sense), .ser_en(ser_en),
      .ser_in(ser_in), .ser_out(ser_out), .drv_en(drv_en),
      .drv_val(drv_val), .fail(fail)
   );

   // Expected {drv_en, drv_val} for a code given the shift strobe level.
   function automatic logic [1:0] exp_pin(input logic [2:0] c, input logic p);
      case (c)
         3'd0:    return 2'b10;
         3'd1:    return 2'b11;
         3'd2:    return {1'b1, p};
         3'd3:    return {1'b1, ~p};
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic exp_miss(input logic [2:0] c, input logic [1:0] s);
      case (c)
         3'd4:    return s != 2'b00;
         3'd5:    return s != 2'b01;
         3'd6:    return !s[1];
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ctl_write(input logic en, input logic hold);
      ctl_wr = 1'b1;
      ctl_wdata = {en, hold};
      step();
      ctl_wr = 1'b0;
   endtask

   task automatic pulse_mux();
      mux_pulse = 1'b1;
      step();
      mux_pulse = 1'b0;
   endtask

   task automatic pulse_shift();
      shift_pulse = 1'b1;
      step();
      shift_pulse = 1'b0;
   endtask

   task automatic load_frame(input logic [5:0] w);
      ser_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         ser_in = w[i];
         step();
      end
      ser_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      rst = 1'b1; ctl_wr = 1'b0; ctl_wdata = 2'b00; force_static = 1'b0;
      mux_pulse = 1'b0; shift_pulse = 1'b0; pin_sense = 2'b00;
      ser_en = 1'b0; ser_in = 1'b0;
      @(negedge clk);
      step(); step();
      rst = 1'b0;
      chk("R1 driver off after reset", {drv_en, drv_val}, 2'b00);
      chk("R1 fail clear after reset", {1'b0, fail}, 2'b00);

      // Drive-only pattern with fixed pulse and level codes in the first slots.
      for (int s = 0; s < DEPTH; s++)
         for (int p = 0; p < 2; p++) pat_a[s][p] = 3'($urandom & 3);
      pat_a[0][0] = 3'd2; pat_a[0][1] = 3'd3;
      pat_a[1][0] = 3'd0; pat_a[1][1] = 3'd1;

      ctl_write(1'b0, 1'b0);
      pulse_mux(); pulse_shift(); // R11: ignored while disabled
      chk("R11 strobes ignored while disabled", {drv_en, drv_val}, 2'b00);
      for (int s = 0; s < DEPTH; s++) load_frame({pat_a[s][1], pat_a[s][0]});

      ctl_write(1'b1, 1'b0);
      load_frame(6'h3f); // R11: serial ignored while enabled
      for (int s = 0; s < DEPTH; s++) begin
         for (int p = 0; p < 2; p++) begin
            step();
            chk((pat_a[s][p] < 2) ? "R2 level drive" : "R3 pulse idle level",
                {drv_en, drv_val}, exp_pin(pat_a[s][p], 1'b0));
            pulse_shift();
            chk((pat_a[s][p] < 2) ? "R2 level at strobe" : "R3 pulse active level",
                {drv_en, drv_val}, exp_pin(pat_a[s][p], 1'b1));
            pulse_mux(); // R8 phase and address advance
         end
      end
      step();
      chk("R8 address wrap to entry 0", {drv_en, drv_val}, exp_pin(pat_a[0][0], 1'b0));
      chk("R11 store kept while enabled", {drv_en, drv_val}, 2'b10);

      // Compare pattern with fixed cases for match, mismatch and stickiness.
      for (int s = 0; s < DEPTH; s++)
         for (int p = 0; p < 2; p++) begin
            pat_b[s][p]   = 3'(4 | ($urandom & 3));
            sense_b[s][p] = 2'($urandom % 3);
         end
      pat_b[0][0] = 3'd6; sense_b[0][0] = 2'b10;
      pat_b[0][1] = 3'd7; sense_b[0][1] = 2'b01;
      pat_b[1][0] = 3'd5; sense_b[1][0] = 2'b00;
      pat_b[1][1] = 3'd4; sense_b[1][1] = 2'b00;
      pat_b[2][0] = 3'd6; sense_b[2][0] = 2'b01;

      ctl_write(1'b0, 1'b0);
      pulse_mux(); pulse_mux(); pulse_mux(); // R11: must not move the load address
      for (int s = 0; s < DEPTH; s++) load_frame({pat_b[s][1], pat_b[s][0]});
      ctl_write(1'b1, 1'b0);
      exp_fail = 1'b0;
      for (int s = 0; s < DEPTH; s++) begin
         for (int p = 0; p < 2; p++) begin
            pin_sense = sense_b[s][p];
            pulse_shift();
            exp_fail = exp_fail | exp_miss(pat_b[s][p], sense_b[s][p]);
            resp_b[s][p] = (sense_b[s][p] == 2'b01);
            chk("R5 sticky fail flag", {1'b0, fail}, {1'b0, exp_fail});
            chk("R4 compare turns driver off", {drv_en, drv_val}, 2'b00);
            pulse_mux();
         end
      end

      ctl_write(1'b0, 1'b0);
      for (int s = 0; s < DEPTH; s++) begin
         ser_en = 1'b1;
         for (int i = 0; i < 6; i++) begin
            ser_in = (i < 3) ? pat_b[s][0][i] : pat_b[s][1][i-3];
            chk("R6 response unload", {1'b0, ser_out},
                {1'b0, (i < 2) ? resp_b[s][i] : 1'b0});
            step();
         end
         ser_en = 1'b0;
      end

      rst = 1'b1;
      step(); step();
      rst = 1'b0;
      chk("R1 fail cleared by reset", {1'b0, fail}, 2'b00);
      pulse_shift();
      chk("R1 enable cleared by reset", {drv_en, drv_val}, 2'b00);

      ctl_write(1'b0, 1'b0);
      for (int s = 0; s < DEPTH; s++) load_frame({pat_a[s][1], pat_a[s][0]});
      ctl_write(1'b1, 1'b0);
      pulse_mux();
      step();
      held = exp_pin(pat_a[0][1], 1'b0);
      chk("R8 phase 1 selected", {drv_en, drv_val}, held);
      force_static = 1'b1;
      pulse_mux(); pulse_shift(); pulse_mux();
      chk("R10 force_static freezes outputs", {drv_en, drv_val}, held);
      force_static = 1'b0;
      step();
      chk("R10 position kept under force_static", {drv_en, drv_val}, held);
      pulse_shift();
      chk("R3 pulse low code at strobe", {drv_en, drv_val}, exp_pin(pat_a[0][1], 1'b1));
      ctl_write(1'b1, 1'b1);
      pulse_mux(); pulse_shift(); pulse_mux();
      chk("R10 local hold freezes outputs", {drv_en, drv_val}, held);
      ctl_write(1'b1, 1'b0);
      step();
      chk("R9 control write clears phase and address", {drv_en, drv_val},
          exp_pin(pat_a[0][0], 1'b0));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule